// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block is a watchdog that shares a free-running 16-bit counter with other counter channels instead of owning a dedicated down-counter. One compare channel is reused for it. The channel's upper byte holds the timeout point and is compared with the counter's upper byte. Its lower byte holds a service offset. Software keeps the watchdog quiet by writing anything to the compare upper byte. That write is turned into a reload of "current counter upper byte plus offset". If the counter's upper byte reaches the compare value first, the block raises a one-cycle reset request.

The watchdog comes out of reset enabled. While it is enabled, it takes over several controls of the counter array. The counter runs whether or not software asked for it. Writes to the counter bytes, the clock-source field, the idle bit and the channel mode register are dropped. The channel mode reads back as the software-timer compare mode. Software clears the enable bit to regain those controls, and can then reconfigure and re-enable the watchdog.

Access uses a simple register port: a write strobe with address and data, plus a separate combinational read address. The counter advances on a clock-enable tick supplied from outside.

Top module: `ctr_watchdog`

## Requirements
- R1: After reset, the register map reads as follows. Control (address 0) reads 0x80: enable bit 7 is set, and the run bit 0, idle bit 1 and source field bits 4:2 are all 0. Counter low (address 1), counter high (address 2), offset (address 4) and compare (address 5) all read 0. Channel mode (address 3) reads 0x48, and `rst_req` is 0.
- R2: The counter advances by one on each cycle in which `tick` is high and either the enable bit or the run bit is set. With both bits clear, `tick` has no effect.
- R3: With the watchdog enabled, a `tick` that moves the counter's upper byte onto the compare value makes `rst_req` high for exactly the following cycle.
- R4: While the watchdog is enabled, a write to address 5 discards its data and loads (counter upper byte + offset). While it is disabled, the same write stores the written data.
- R5: The run bit (control bit 0) reads back the value software last wrote to it, even while the watchdog is enabled. While the watchdog is enabled, changing the run bit has no effect on counting.
- R6: While the watchdog is enabled, writes to addresses 1 and 2 are ignored. While it is disabled, they load the counter bytes.
- R7: While the watchdog is enabled, the idle bit and the source field keep their values across control writes.
- R8: While the watchdog is enabled, address 3 reads 0x48 and writes to it are ignored. Once the watchdog is disabled, address 3 reads the stored mode value and accepts writes again.
- R9: A control write that clears bit 7 takes effect at the next clock edge. The idle bit and source field carried in that same write are still ignored, and later writes are accepted. No `rst_req` occurs while the watchdog is disabled, even when the upper bytes match.
- R10: The service sum wraps modulo 256. For example, an upper byte of 0xFF with an offset of 0x05 reloads the compare value as 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench measures the exact number of unserviced ticks to the first reset request, checks that the pulse lasts exactly one cycle, and confirms that periodic servicing yields none. A design that compared on every cycle, or ignored the tick, would give a wrong count or a pulse train. It attempts every locked write while the watchdog is enabled and reads each register back, and also checks the frozen fields on the very write that clears the enable. A design that applied the clearing one cycle early would let the source field change at that point. It also forces an upper-byte match with the watchdog disabled, and a service at counter upper byte 0xFF, where a missing modulo-256 wrap would show.

// File: rtl/wdc_pkg.sv
// Package: shared register addresses, control bit positions and constants
// for the counter-compare watchdog. Assumes a byte-wide register port.
package wdc_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNTL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNTH = 3'd2;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd3;
    localparam logic [ADDR_W-1:0] A_OFS  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMPH = 3'd5;

    localparam int unsigned CTL_RUN  = 0;
    localparam int unsigned CTL_IDLE = 1;
    localparam int unsigned CTL_SRC  = 2;
    localparam int unsigned SRC_W    = 3;
    localparam int unsigned CTL_WDEN = 7;

    // Mode value forced onto the channel while the watchdog owns it.
    localparam logic [7:0] MODE_SWTIMER = 8'h48;
endpackage

// File: rtl/wdc_ctrl.sv
// Control and mode registers. The enable bit and run bit are always
// writable; the idle bit, source field and mode register are locked while
// the current enable value is set. Assumes an 8-bit write data slice.
module wdc_ctrl
    import wdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_mode,
    input  logic [7:0]        wdat,
    output logic              wd_en,
    output logic              run_sw,
    output logic              idle_ctl,
    output logic [SRC_W-1:0]  src_sel,
    output logic [7:0]        mode_reg
);
    // Register update with lockout decided by the pre-write enable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_en    <= 1'b1;
            run_sw   <= 1'b0;
            idle_ctl <= 1'b0;
            src_sel  <= '0;
            mode_reg <= '0;
        end else begin
            if (wr_ctl) begin
                wd_en  <= wdat[CTL_WDEN];
                run_sw <= wdat[CTL_RUN];
                if (!wd_en) begin
                    idle_ctl <= wdat[CTL_IDLE];
                    src_sel  <= wdat[CTL_SRC +: SRC_W];
                end
            end
            if (wr_mode && !wd_en) begin
                mode_reg <= wdat;
            end
        end
    end
endmodule

// File: rtl/wdc_counter.sv
// Shared 2*W-bit counter. Advances on tick when run is high; byte writes
// are honoured only when lock is low and win over the increment.
// hi_step flags the advance that carries into the upper byte.
module wdc_counter #(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           run,
    input  logic           lock,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W-1:0]   wdat,
    output logic [2*W-1:0] cnt,
    output logic           hi_step
);
    localparam int unsigned CW = 2 * W;
    localparam logic [CW-1:0] CNT_ONE = 1;

    logic           adv;
    logic [CW-1:0]  cnt_nxt;

    assign adv     = tick && run;
    assign hi_step = adv && (cnt[W-1:0] == {W{1'b1}});

    // Next-state: increment, then unlocked byte loads override.
    always_comb begin
        cnt_nxt = cnt;
        if (adv)            cnt_nxt = cnt + CNT_ONE;
        if (wr_lo && !lock) cnt_nxt[W-1:0]  = wdat;
        if (wr_hi && !lock) cnt_nxt[CW-1:W] = wdat;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/wdc_compare.sv
// Watchdog compare channel: offset byte, compare byte with service reload,
// and the registered one-cycle reset request. Assumes hi_step is high only
// on the tick that changes the counter upper byte.
module wdc_compare #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wd_en,
    input  logic         wr_ofs,
    input  logic         wr_cmp,
    input  logic [W-1:0] wdat,
    input  logic [W-1:0] cnt_hi,
    input  logic         hi_step,
    output logic [W-1:0] ofs,
    output logic [W-1:0] cmp_hi,
    output logic         rst_req
);
    localparam logic [W-1:0] ONE = 1;

    logic [W-1:0] hi_next;
    logic [W-1:0] reload;

    assign hi_next = cnt_hi + ONE;
    assign reload  = cnt_hi + ofs;

    // Offset and compare bytes; a compare write services when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs    <= '0;
            cmp_hi <= '0;
        end else begin
            if (wr_ofs) ofs <= wdat;
            if (wr_cmp) cmp_hi <= wd_en ? reload : wdat;
        end
    end

    // Reset request: match on the upper-byte step, one cycle wide.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= wd_en && hi_step && (hi_next == cmp_hi);
    end
endmodule

// File: rtl/ctr_watchdog.sv
// Top: counter-compare watchdog. Decodes the register port, forces the
// counter to run while enabled and muxes read data. Assumes BYTE_W >= 8.
module ctr_watchdog
    import wdc_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rst_req
);
    localparam int unsigned CW = 2 * BYTE_W;

    logic              wd_en, run_sw, idle_ctl, hi_step;
    logic [SRC_W-1:0]  src_sel;
    logic [7:0]        mode_reg, ctl_view, mode_view;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] ofs, cmp_hi;

    wdc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (wr_en && wr_addr == A_CTL),
        .wr_mode  (wr_en && wr_addr == A_MODE),
        .wdat     (wr_data[7:0]),
        .wd_en    (wd_en),
        .run_sw   (run_sw),
        .idle_ctl (idle_ctl),
        .src_sel  (src_sel),
        .mode_reg (mode_reg)
    );

    wdc_counter #(.W(BYTE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run_sw || wd_en),
        .lock    (wd_en),
        .wr_lo   (wr_en && wr_addr == A_CNTL),
        .wr_hi   (wr_en && wr_addr == A_CNTH),
        .wdat    (wr_data),
        .cnt     (cnt),
        .hi_step (hi_step)
    );

    wdc_compare #(.W(BYTE_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wd_en   (wd_en),
        .wr_ofs  (wr_en && wr_addr == A_OFS),
        .wr_cmp  (wr_en && wr_addr == A_CMPH),
        .wdat    (wr_data),
        .cnt_hi  (cnt[CW-1:BYTE_W]),
        .hi_step (hi_step),
        .ofs     (ofs),
        .cmp_hi  (cmp_hi),
        .rst_req (rst_req)
    );

    // Read views of the control byte and the (possibly forced) mode.
    always_comb begin
        ctl_view = '0;
        ctl_view[CTL_WDEN]           = wd_en;
        ctl_view[CTL_RUN]            = run_sw;
        ctl_view[CTL_IDLE]           = idle_ctl;
        ctl_view[CTL_SRC +: SRC_W]   = src_sel;
        mode_view = wd_en ? MODE_SWTIMER : mode_reg;
    end

    // Combinational read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CTL:   rd_data = BYTE_W'(ctl_view);
            A_CNTL:  rd_data = cnt[BYTE_W-1:0];
            A_CNTH:  rd_data = cnt[CW-1:BYTE_W];
            A_MODE:  rd_data = BYTE_W'(mode_view);
            A_OFS:   rd_data = ofs;
            A_CMPH:  rd_data = cmp_hi;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdc_checker.sv
// Checker bound to ctr_watchdog: temporal properties on the request pulse,
// forced counting, lockouts and service reload.
module wdc_checker
    import wdc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wd_en,
    input logic              idle_ctl,
    input logic [SRC_W-1:0]  src_sel,
    input logic [7:0]        mode_reg,
    input logic [2*W-1:0]    cnt,
    input logic [W-1:0]      ofs,
    input logic [W-1:0]      cmp_hi,
    input logic              rst_req
);
    localparam logic [2*W-1:0] CNT_ONE = 1;

    assert_pulse_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_req_only_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wd_en));

    assert_forced_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && tick) |=> (cnt == $past(cnt) + CNT_ONE));

    assert_cnt_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && !tick) |=> $stable(cnt));

    assert_fields_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en |=> ($stable(src_sel) && $stable(idle_ctl)));

    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en |=> $stable(mode_reg));

    assert_service_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && wr_en && wr_addr == A_CMPH) |=>
        (cmp_hi == W'($past(cnt[2*W-1:W]) + $past(ofs))));
endmodule

bind ctr_watchdog wdc_checker #(.W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wd_en    (wd_en),
    .idle_ctl (idle_ctl),
    .src_sel  (src_sel),
    .mode_reg (mode_reg),
    .cnt      (cnt),
    .ofs      (ofs),
    .cmp_hi   (cmp_hi),
    .rst_req  (rst_req)
);

// File: tb/tb_ctr_watchdog.sv
`timescale 1ns/1ps
module tb_ctr_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rst_req;

    int errors = 0;
    int checks = 0;
    int pulses = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } sb_item_t;
    sb_item_t sb[$];

    ctr_watchdog dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rst_req(rst_req)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Driver: select a read address and push the expected value.
    task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        rd_addr = a;
        sb.push_back('{exp: e, req: req});
    endtask

    // Monitor: pop the expected item and compare the read data.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                check({24'd0, rd_data}, {24'd0, it.exp}, it.req);
            end
        end
    end

    // Count request pulses seen at the falling edge.
    always @(negedge clk) if (rst_n && rst_req) pulses++;

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        int hit;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check({31'd0, rst_req}, 32'd0, "R1 rst_req");
        expect_rd(3'd0, 8'h80, "R1 ctl");
        expect_rd(3'd1, 8'h00, "R1 cntl");
        expect_rd(3'd2, 8'h00, "R1 cnth");
        expect_rd(3'd3, 8'h48, "R1 mode");
        expect_rd(3'd4, 8'h00, "R1 ofs");
        expect_rd(3'd5, 8'h00, "R1 cmp");

        // R6/R7/R8/R5: lockouts while enabled
        wr(3'd1, 8'h55); expect_rd(3'd1, 8'h00, "R6 cntl locked");
        wr(3'd2, 8'h66); expect_rd(3'd2, 8'h00, "R6 cnth locked");
        wr(3'd0, 8'h9C); expect_rd(3'd0, 8'h80, "R7 src frozen");
        wr(3'd0, 8'h82); expect_rd(3'd0, 8'h80, "R7 idle frozen");
        wr(3'd3, 8'h11); expect_rd(3'd3, 8'h48, "R8 mode forced");
        wr(3'd0, 8'h81); expect_rd(3'd0, 8'h81, "R5 run reads 1");
        wr(3'd0, 8'h80); expect_rd(3'd0, 8'h80, "R5 run reads 0");

        // R2/R5: counter forced on with run bit 0
        tick_n(5);
        expect_rd(3'd1, 8'h05, "R2 forced count");
        expect_rd(3'd2, 8'h00, "R2 cnth");

        // R4: service loads hi + offset
        wr(3'd4, 8'h03);
        wr(3'd5, 8'hAA);
        expect_rd(3'd5, 8'h03, "R4 service reload");

        // R3: timeout after 0x300 - 5 = 763 ticks
        hit = 0;
        @(negedge clk); tick = 1'b1;
        for (int i = 1; i <= 800; i++) begin
            @(negedge clk);
            if (rst_req) begin hit = i; break; end
        end
        check(hit, 763, "R3 ticks to reset");
        @(negedge clk);
        check({31'd0, rst_req}, 32'd0, "R3 pulse width");
        tick = 1'b0;

        // R3/R4: periodic service prevents the request
        wr(3'd5, 8'h00);
        p0 = pulses;
        @(negedge clk); tick = 1'b1;
        for (int k = 0; k < 15; k++) begin
            repeat (198) @(negedge clk);
            wr(3'd5, 8'h00);
        end
        tick = 1'b0;
        check(pulses - p0, 0, "R3 serviced no reset");

        // R9: clearing write still frozen, later writes accepted
        wr(3'd0, 8'h1C); expect_rd(3'd0, 8'h00, "R9 clear write frozen");
        wr(3'd0, 8'h1C); expect_rd(3'd0, 8'h1C, "R9 writes accepted");
        expect_rd(3'd3, 8'h00, "R8 stored mode");
        wr(3'd3, 8'h11); expect_rd(3'd3, 8'h11, "R8 mode writable");
        wr(3'd1, 8'h00); wr(3'd2, 8'hFE);
        expect_rd(3'd2, 8'hFE, "R6 cnth load");
        expect_rd(3'd1, 8'h00, "R6 cntl load");
        tick_n(3);
        expect_rd(3'd1, 8'h00, "R2 stopped");
        wr(3'd5, 8'hFF); expect_rd(3'd5, 8'hFF, "R4 plain store");

        // R9: match while disabled gives no request
        wr(3'd0, 8'h1D);
        p0 = pulses;
        tick_n(256);
        expect_rd(3'd2, 8'hFF, "R2 run bit count");
        check(pulses - p0, 0, "R9 no reset disabled");

        // R10: wrap of the service sum
        wr(3'd4, 8'h05);
        wr(3'd0, 8'h9D);
        wr(3'd5, 8'h12);
        expect_rd(3'd5, 8'h04, "R10 wrap");
        expect_rd(3'd0, 8'h9D, "R9 re-enable");
        expect_rd(3'd3, 8'h48, "R8 forced again");

        @(negedge clk); #2;
        finish_run();
    end
endmodule